// File: doc/BRIEF.md
# Self-Timed Page Program Sequencer

This block carries out the internal, self-timed commit of a one-page staging buffer into a page of a small flash-like array. The command front-end first streams bytes into the staging buffer. It then offers one program request, which names the target page, an erase flag and a per-byte valid mask. Once the request is accepted, the sequencer runs on its own through up to three phases, shown on a busy pin:

- an optional whole-page erase;
- a byte-by-byte program phase;
- a read-back verify pass.

The array model is a synchronous RAM in which an erased bit reads 1. Programming can only clear bits, so a byte written with value `d` becomes `old & d`.

With the erase flag set, every byte of the page ends up holding the buffer contents. With the flag clear, only the bytes whose mask bit is set are programmed. The other bytes of the page keep their old values. The verify pass compares each programmed byte with the buffer and raises a sticky error flag on any difference. A typical case is an attempt to turn a 0 back into a 1 without an erase.

Both streaming inputs use valid/ready. The request port and the buffer-fill port each present `ready` exactly while the sequencer is idle. A transfer happens on a clock edge where `valid` and `ready` are both high. A source may hold `valid` high while `ready` is low, and nothing is taken. The read port and the status pins are plain signals.

Top module: `pgm_seq`

## Requirements
- R1: After reset, `busy` and `err` are 0, `req_ready` and `wr_ready` are 1, and every array byte reads 0xFF.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and `req_ready` is 0 while `busy` is 1. A request offered while busy is not taken and does not change the page or result of the running operation.
- R3: A buffer byte is written at `wr_addr` on an edge with `wr_valid` and `wr_ready` both high. `wr_ready` is 0 while busy, so a write offered during an operation leaves the buffer, and hence the programmed data, unchanged.
- R4: With `req_erase`=1, the addressed page is first erased to 0xFF in every byte and then every byte is programmed, so afterwards byte i of the page equals buffer byte i.
- R5: With `req_erase`=0, byte i of the page (bit i of `req_mask` selects byte offset i) becomes `old & buffer[i]` when its mask bit is 1, and keeps its old value when the bit is 0.
- R6: Bytes of pages other than the addressed one are never changed by an operation.
- R7: `busy` rises the cycle after acceptance and stays high for exactly PAGE_BYTES*ERASE_CYC (erase mode only) + PAGE_BYTES*PROG_CYC + 2*PAGE_BYTES + 1 cycles. The last of these is the DONE cycle.
- R8: When `busy` falls, `err` is 1 exactly when some checked byte (every byte in erase mode, masked bytes otherwise) reads back different from its buffer byte.
- R9: `err` is 0 in the cycle after a request is accepted, and while idle it holds its value until the next acceptance.
- R10: With the read address `rd_addr` = page*PAGE_BYTES + offset applied, `rd_data` shows that array byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Program request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_page | input | PAGE_AW | Target page number |
| req_erase | input | 1 | 1: erase then program all bytes; 0: program masked bytes only |
| req_mask | input | PAGE_BYTES | Bit i marks buffer byte i as written |
| wr_valid | input | 1 | Buffer byte write offered |
| wr_ready | output | 1 | Buffer write can be taken (idle) |
| wr_addr | input | BYTE_AW | Buffer byte offset |
| wr_data | input | BYTE_W | Buffer byte value |
| rd_addr | input | ADDR_W | Array read address, page*PAGE_BYTES+offset |
| rd_data | output | BYTE_W | Array byte, one cycle after rd_addr |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky verify failure of the last operation |

## Verification
A wrong state or index inside the sequencer shows up at the ports in two ways. The busy window has a closed-form length, so a skipped or repeated phase shifts the falling edge of `busy`, and this is seen in the very operation that went wrong. A byte that is wrongly erased or programmed, or that lands in the wrong page, is seen on the read port as soon as the operation ends, because the bench compares the whole array against an arithmetic AND model after every run. A compare done at the wrong byte or against stale data changes `err` against the model's verify prediction. The bound checker catches bad erase or program strobes in the cycle they occur: an erase without the flag, a program to an unmasked byte, or a strobe to another page.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ERASE   = 3'd1,
    ST_PROGRAM = 3'd2,
    ST_VERIFY  = 3'd3,
    ST_DONE    = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pgm_buffer.sv
module pgm_buffer #(
  parameter int PAGE_BYTES = 8,
  parameter int BYTE_W     = 8,
  localparam int BYTE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [BYTE_AW-1:0] waddr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [BYTE_AW-1:0] raddr,
  output logic [BYTE_W-1:0]  rdata
);
  logic [BYTE_W-1:0] stage_q [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) stage_q[i] <= '1;
    end else if (we) begin
      stage_q[waddr] <= wdata;
    end
  end

  assign rdata = stage_q[raddr];
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 8,
  parameter int BYTE_W     = 8,
  localparam int DEPTH     = NUM_PAGES * PAGE_BYTES,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              er,
  input  logic              pg,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [BYTE_W-1:0] pg_data,
  output logic [BYTE_W-1:0] op_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [BYTE_W-1:0] host_rdata
);
  logic [BYTE_W-1:0] cell_q [DEPTH];

  // Erase sets a byte to all ones; program can only clear bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (er) begin
      cell_q[op_addr] <= '1;
    end else if (pg) begin
      cell_q[op_addr] <= cell_q[op_addr] & pg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_rdata   <= '1;
      host_rdata <= '1;
    end else begin
      op_rdata   <= cell_q[op_addr];
      host_rdata <= cell_q[host_addr];
    end
  end
endmodule

// File: rtl/pgm_fsm.sv
module pgm_fsm
  import pgm_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int ERASE_CYC  = 2,
  parameter int PROG_CYC   = 3,
  localparam int BYTE_AW   = $clog2(PAGE_BYTES),
  localparam int PAGE_AW   = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PAGE_AW + BYTE_AW,
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAGE_AW-1:0]    start_page,
  input  logic                  start_erase,
  input  logic [PAGE_BYTES-1:0] start_mask,
  output logic [BYTE_AW-1:0]    buf_raddr,
  input  logic [BYTE_W-1:0]     buf_rdata,
  output logic                  arr_er,
  output logic                  arr_pg,
  output logic [ADDR_W-1:0]     arr_addr,
  output logic [BYTE_W-1:0]     arr_wdata,
  input  logic [BYTE_W-1:0]     arr_rdata,
  output logic                  busy,
  output logic                  err
);
  localparam logic [BYTE_AW-1:0] LAST_IDX = BYTE_AW'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0]   ER_END   = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0]   PG_END   = CNT_W'(PROG_CYC - 1);

  seq_state_t            state_q;
  logic [PAGE_AW-1:0]    page_q;
  logic                  erase_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [BYTE_AW-1:0]    idx_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  vphase_q;
  logic                  err_q;
  logic                  sel_byte;

  assign sel_byte  = erase_q | mask_q[idx_q];
  assign arr_addr  = {page_q, idx_q};
  assign buf_raddr = idx_q;
  assign arr_wdata = buf_rdata;
  assign arr_er    = (state_q == ST_ERASE) && (cnt_q == ER_END);
  assign arr_pg    = (state_q == ST_PROGRAM) && (cnt_q == PG_END) && sel_byte;
  assign busy      = (state_q != ST_IDLE);
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      erase_q  <= 1'b0;
      mask_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      vphase_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            page_q   <= start_page;
            erase_q  <= start_erase;
            mask_q   <= start_mask;
            idx_q    <= '0;
            cnt_q    <= '0;
            vphase_q <= 1'b0;
            err_q    <= 1'b0;
            state_q  <= start_erase ? ST_ERASE : ST_PROGRAM;
          end
        end
        ST_ERASE: begin
          if (cnt_q == ER_END) begin
            cnt_q <= '0;
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              state_q <= ST_PROGRAM;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROGRAM: begin
          if (cnt_q == PG_END) begin
            cnt_q <= '0;
            if (idx_q == LAST_IDX) begin
              idx_q    <= '0;
              vphase_q <= 1'b0;
              state_q  <= ST_VERIFY;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_VERIFY: begin
          // Phase 0 presents the address, phase 1 compares the read-back.
          if (!vphase_q) begin
            vphase_q <= 1'b1;
          end else begin
            vphase_q <= 1'b0;
            if (sel_byte && (arr_rdata != buf_rdata)) err_q <= 1'b1;
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq #(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int ERASE_CYC  = 2,
  parameter int PROG_CYC   = 3,
  localparam int BYTE_AW   = $clog2(PAGE_BYTES),
  localparam int PAGE_AW   = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PAGE_AW + BYTE_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PAGE_AW-1:0]    req_page,
  input  logic                  req_erase,
  input  logic [PAGE_BYTES-1:0] req_mask,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [BYTE_AW-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [BYTE_W-1:0]     rd_data,
  output logic                  busy,
  output logic                  err
);
  logic               seq_busy;
  logic               accept;
  logic [BYTE_AW-1:0] buf_raddr;
  logic [BYTE_W-1:0]  buf_rdata;
  logic               arr_er;
  logic               arr_pg;
  logic [ADDR_W-1:0]  arr_addr;
  logic [BYTE_W-1:0]  arr_wdata;
  logic [BYTE_W-1:0]  arr_rdata;

  assign req_ready = !seq_busy;
  assign wr_ready  = !seq_busy;
  assign accept    = req_valid && req_ready;
  assign busy      = seq_busy;

  pgm_buffer #(.PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_valid && wr_ready),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  pgm_array #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .er         (arr_er),
    .pg         (arr_pg),
    .op_addr    (arr_addr),
    .pg_data    (arr_wdata),
    .op_rdata   (arr_rdata),
    .host_addr  (rd_addr),
    .host_rdata (rd_data)
  );

  pgm_fsm #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_page  (req_page),
    .start_erase (req_erase),
    .start_mask  (req_mask),
    .buf_raddr   (buf_raddr),
    .buf_rdata   (buf_rdata),
    .arr_er      (arr_er),
    .arr_pg      (arr_pg),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .arr_rdata   (arr_rdata),
    .busy        (seq_busy),
    .err         (err)
  );
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 8,
  localparam int BYTE_AW   = $clog2(PAGE_BYTES),
  localparam int PAGE_AW   = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PAGE_AW + BYTE_AW
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [PAGE_AW-1:0]    req_page,
  input logic                  req_erase,
  input logic [PAGE_BYTES-1:0] req_mask,
  input logic                  busy,
  input logic                  err,
  input logic                  arr_er,
  input logic                  arr_pg,
  input logic [ADDR_W-1:0]     arr_addr
);
  logic                  acc;
  logic [PAGE_AW-1:0]    c_page;
  logic                  c_erase;
  logic [PAGE_BYTES-1:0] c_mask;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_page  <= '0;
      c_erase <= 1'b0;
      c_mask  <= '0;
    end else if (acc) begin
      c_page  <= req_page;
      c_erase <= req_erase;
      c_mask  <= req_mask;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc);

  p_erase_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_er |-> (c_erase && busy));

  p_masked_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_pg && !c_erase) |-> c_mask[arr_addr[BYTE_AW-1:0]]);

  p_page_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_er || arr_pg) |-> (arr_addr[ADDR_W-1:BYTE_AW] == c_page));

  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_er || arr_pg) |-> busy);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !err);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc) |=> $stable(err));
endmodule

bind pgm_seq pgm_seq_chk #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_page  (req_page),
  .req_erase (req_erase),
  .req_mask  (req_mask),
  .busy      (busy),
  .err       (err),
  .arr_er    (arr_er),
  .arr_pg    (arr_pg),
  .arr_addr  (arr_addr)
);

// File: tb/pgm_seq_tb.sv
module pgm_seq_tb;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int EC = 2;
  localparam int PC = 3;
  localparam int DEPTH = NP * NB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_page = '0;
  logic       req_erase = 1'b0;
  logic [7:0] req_mask = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;
  logic       err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] bm [NB];

  always #5 clk = ~clk;

  pgm_seq #(.NUM_PAGES(NP), .PAGE_BYTES(NB), .BYTE_W(8),
            .ERASE_CYC(EC), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .req_erase(req_erase), .req_mask(req_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) ^ (i << 4));
  endfunction

  task automatic fill_buf(input logic [7:0] d [NB]);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 3'(i); wr_data = d[i];
      bm[i] = d[i];
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic check_array(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_addr = 5'(a);
      @(negedge clk);
      chk(rd_data == model[a], tag, rd_data, model[a]);
    end
  endtask

  // Runs one operation, updates the model and checks busy length and err.
  task automatic run_op(input int pg, input bit er, input logic [7:0] msk, input bit disturb);
    int cnt;
    bit exp_err;
    int exp_len;
    exp_err = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (er) begin
        model[pg*NB+i] = bm[i];
      end else if (msk[i]) begin
        if ((model[pg*NB+i] & bm[i]) != bm[i]) exp_err = 1'b1;
        model[pg*NB+i] = model[pg*NB+i] & bm[i];
      end
    end
    exp_len = (er ? NB*EC : 0) + NB*PC + 2*NB + 1;
    @(negedge clk);
    req_valid = 1'b1; req_page = 2'(pg); req_erase = er; req_mask = msk;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 2000) begin
      if (cnt == 0) begin
        chk(err == 1'b0, "R9 err cleared after accept", err, 0);
        chk(req_ready == 1'b0 && wr_ready == 1'b0, "R2 ready low while busy",
            {req_ready, wr_ready}, 0);
        if (disturb) begin
          req_valid = 1'b1; req_page = 2'(pg ^ 1); req_erase = 1'b1; req_mask = '1;
          wr_valid = 1'b1; wr_addr = '0; wr_data = ~bm[0];
        end
      end
      cnt++;
      @(negedge clk);
    end
    req_valid = 1'b0; wr_valid = 1'b0;
    chk(cnt == exp_len, "R7 busy length", cnt, exp_len);
    chk(err == exp_err, "R8 verify error flag", err, exp_err);
    @(negedge clk);
    chk(busy == 1'b0, "R2 stray request not taken", busy, 0);
    chk(err == exp_err, "R9 err held while idle", err, exp_err);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [NB];
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    for (int i = 0; i < NB; i++) bm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(err == 1'b0, "R1 err at reset", err, 0);
    chk(req_ready && wr_ready, "R1 ready at reset", {req_ready, wr_ready}, 3);
    check_array("R1 R10 erased array read");

    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 3; s++) begin
        // R4 erase mode, R3 buffer fill; disturbed run tests R2/R3 ignore
        for (int i = 0; i < NB; i++) d[i] = pat(s + p * 3, i);
        fill_buf(d);
        run_op(p, 1'b1, 8'h00, s == 1);
        check_array("R4 R6 erase-mode page");
        // R5 no-erase mode with a mask; may produce verify error (R8)
        for (int i = 0; i < NB; i++) d[i] = pat(s + 7 + p, i);
        fill_buf(d);
        run_op(p, 1'b0, 8'(8'hA5 ^ (s * 8'h33)), 1'b0);
        check_array("R5 R6 masked program");
        // R5 R8 clears only: AND of current contents, never an error
        for (int i = 0; i < NB; i++) d[i] = model[p*NB+i] & pat(s + 21, i);
        fill_buf(d);
        run_op(p, 1'b0, 8'hFF, 1'b0);
        check_array("R5 clear-only program");
      end
      // R5 empty mask leaves the page untouched
      for (int i = 0; i < NB; i++) d[i] = 8'h00;
      fill_buf(d);
      run_op(p, 1'b0, 8'h00, 1'b0);
      check_array("R5 empty mask no change");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule